// File: doc/BRIEF.md
# Synchronizable PWM Channel

This block is one PWM channel built around a free-running counter. While it runs, the counter climbs by one each clock up to a programmed period value and then returns to zero, so one PWM cycle lasts period+1 clocks. The output is in its active state while the counter is below a programmed compare value. A polarity bit chooses whether the active state is driven high or low.

A sync input can reload the counter from a phase register. A sync output can be sourced from the channel's own period match, from a delayed copy of the sync input, or turned off. One channel acts as the timing source and pulses its sync output at every period match. Further channels take that pulse as their sync input and reload their counters with phase 0. Intermediate channels forward the pulse down the chain, one clock later per stage, and the last channel has its sync output turned off. Every channel in the chain must run at an integer multiple of the source frequency, so a reload never cuts a target cycle short and no beat frequency appears. Software sets up the channel through a small write-only register port.

Top module: `sync_pwm_channel`

## Requirements
- R1: After reset the counter reads 0, pwmOut and syncOut are 0, and the channel is stopped with sync input disabled and sync output off.
- R2: While running, the counter rises by one per clock. On the clock after it equals or exceeds the period register, it returns to 0, so a PWM cycle lasts period+1 clocks.
- R3: When the run bit is clear, the counter holds its value.
- R4: The output is active in exactly those cycles where the counter is below the compare register. A compare of 0 never activates it, and a compare above the period keeps it active for the whole cycle.
- R5: Control bit 4 selects polarity: 0 drives the active state high, and 1 drives it low.
- R6: When the sync enable (control bit 1) is set, a sync input pulse loads the phase register into the counter on the next clock. This load takes priority over the wrap and the increment, and it also acts while the channel is stopped.
- R7: When the sync enable is clear, a sync input pulse leaves the counter unchanged.
- R8: With the sync source field (control bits 3:2) set to 01, syncOut is high for one clock. That clock follows a running cycle in which the counter equals the period.
- R9: With the sync source field set to 10, syncOut repeats syncIn one clock later.
- R10: With the sync source field set to 00 or 11, syncOut stays low.
- R11: Address 0 writes the period, address 1 the compare, address 2 the phase, and address 3 the control register (bit 0 run). A write acts from the clock after the one that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select |
| wrData | input | CNT_W | Write data |
| syncIn | input | 1 | Sync pulse from the upstream channel |
| pwmOut | output | 1 | PWM output |
| syncOut | output | 1 | Sync pulse to the downstream channel |
| cntValue | output | CNT_W | Current counter value |

## Verification
The hardest case to reach is a sync pulse that lands in the same cycle as a period wrap. The stimulus first reloads the counter to a known phase. It then counts the clocks until the counter sits exactly on the period and raises syncIn on that cycle, so the reload can be told apart from the wrap to zero. A counter stranded above a shortened period is reached in a similar way. The stimulus reloads an out-of-range phase while the channel is stopped, then starts it and checks that the counter returns to zero.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_PERIOD = 2'd0;
  localparam logic [ADDR_W-1:0] REG_CMP    = 2'd1;
  localparam logic [ADDR_W-1:0] REG_PHASE  = 2'd2;
  localparam logic [ADDR_W-1:0] REG_CTRL   = 2'd3;

  localparam int BIT_RUN   = 0;
  localparam int BIT_SINEN = 1;
  localparam int BIT_SEL0  = 2;
  localparam int BIT_LOW   = 4;

  typedef enum logic [1:0] {
    SO_OFF    = 2'b00,
    SO_PERIOD = 2'b01,
    SO_PASS   = 2'b10,
    SO_OFF2   = 2'b11
  } sync_src_e;

  typedef struct packed {
    logic cntLoad;
    logic cntInc;
    logic cntClear;
    logic syncFire;
  } strobe_t;
endpackage

// File: rtl/spwm_ctrl.sv
module spwm_ctrl
  import spwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              syncIn,
  input  logic [CNT_W-1:0]  cntQ,
  output strobe_t           strb,
  output logic [CNT_W-1:0]  cmpVal,
  output logic [CNT_W-1:0]  phaseVal,
  output logic              activeLow,
  output sync_src_e         srcSel,
  output logic              running
);
  logic [CNT_W-1:0] prdQ, cmpQ, phaseQ;
  logic             runQ, sinEnQ, lowQ;
  sync_src_e        selQ;
  logic             loadHit, atEnd, atPeriod;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prdQ   <= '1;
      cmpQ   <= '0;
      phaseQ <= '0;
      runQ   <= 1'b0;
      sinEnQ <= 1'b0;
      lowQ   <= 1'b0;
      selQ   <= SO_OFF;
    end else if (wrEn) begin
      case (wrAddr)
        REG_PERIOD: prdQ   <= wrData;
        REG_CMP:    cmpQ   <= wrData;
        REG_PHASE:  phaseQ <= wrData;
        default: begin
          runQ   <= wrData[BIT_RUN];
          sinEnQ <= wrData[BIT_SINEN];
          selQ   <= sync_src_e'(wrData[BIT_SEL0+1:BIT_SEL0]);
          lowQ   <= wrData[BIT_LOW];
        end
      endcase
    end
  end

  always_comb begin
    loadHit       = syncIn & sinEnQ;
    atEnd         = (cntQ >= prdQ);
    atPeriod      = (cntQ == prdQ);
    strb.cntLoad  = loadHit;
    strb.cntClear = runQ & atEnd & ~loadHit;
    strb.cntInc   = runQ & ~atEnd & ~loadHit;
    case (selQ)
      SO_PERIOD: strb.syncFire = runQ & atPeriod;
      SO_PASS:   strb.syncFire = syncIn;
      default:   strb.syncFire = 1'b0;
    endcase
  end

  assign cmpVal    = cmpQ;
  assign phaseVal  = phaseQ;
  assign activeLow = lowQ;
  assign srcSel    = selQ;
  assign running   = runQ;
endmodule

// File: rtl/spwm_dp.sv
module spwm_dp
  import spwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] phaseVal,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic             activeLow,
  output logic [CNT_W-1:0] cntQ,
  output logic             pwmOut,
  output logic             syncOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      syncOut <= 1'b0;
    end else begin
      syncOut <= strb.syncFire;
      if (strb.cntLoad)       cntQ <= phaseVal;
      else if (strb.cntClear) cntQ <= '0;
      else if (strb.cntInc)   cntQ <= cntQ + CNT_W'(1);
    end
  end

  assign pwmOut = activeLow ^ (cntQ < cmpVal);

  a_r6_phase_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntLoad |=> cntQ == $past(phaseVal));
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClear |=> cntQ == '0);
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntInc |=> cntQ == $past(cntQ) + CNT_W'(1));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.cntLoad || strb.cntClear || strb.cntInc) |=> $stable(cntQ));
endmodule

// File: rtl/sync_pwm_channel.sv
module sync_pwm_channel
  import spwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             syncIn,
  output logic             pwmOut,
  output logic             syncOut,
  output logic [CNT_W-1:0] cntValue
);
  strobe_t          strb;
  logic [CNT_W-1:0] cmpVal, phaseVal;
  logic             activeLow, running;
  sync_src_e        srcSel;

  spwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .syncIn(syncIn), .cntQ(cntValue), .strb(strb), .cmpVal(cmpVal),
    .phaseVal(phaseVal), .activeLow(activeLow), .srcSel(srcSel),
    .running(running)
  );

  spwm_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .phaseVal(phaseVal),
    .cmpVal(cmpVal), .activeLow(activeLow), .cntQ(cntValue),
    .pwmOut(pwmOut), .syncOut(syncOut)
  );

  a_r10_sync_off: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == SO_OFF || srcSel == SO_OFF2) |=> !syncOut);
  a_r9_pass_delay: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == SO_PASS) |=> syncOut == $past(syncIn));
  a_r8_no_fire_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == SO_PERIOD && !running) |=> !syncOut);
endmodule

// File: tb/sync_pwm_channel_bench.sv
`timescale 1ns/1ps
module sync_pwm_channel_bench;
  localparam int CNT_W = 16;
  localparam int NVEC = 8;
  localparam int VEC_PRD [NVEC] = '{9, 9, 9, 9, 4, 4, 0, 9};
  localparam int VEC_CMP [NVEC] = '{3, 0, 12, 3, 5, 4, 1, 10};
  localparam int VEC_LOW [NVEC] = '{0, 0, 0, 1, 0, 0, 0, 1};
  localparam int VEC_EXP [NVEC] = '{3, 0, 10, 7, 5, 4, 1, 0};

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic             syncIn = 1'b0;
  logic             pwmOut, syncOut;
  logic [CNT_W-1:0] cntValue;
  int nChk = 0;
  int nBad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  sync_pwm_channel #(.CNT_W(CNT_W)) u_sync_pwm_channel (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .syncIn(syncIn), .pwmOut(pwmOut), .syncOut(syncOut), .cntValue(cntValue)
  );

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wrEn = 1'b1; wrAddr = a; wrData = CNT_W'(d);
    tick();
    wrEn = 1'b0;
  endtask

  task automatic pulseSync();
    syncIn = 1'b1;
    tick();
    syncIn = 1'b0;
  endtask

  initial begin
    ticks(3);
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 count", int'(cntValue), 0);
    chk("R1 pwm", int'(pwmOut), 0);
    chk("R1 sync", int'(syncOut), 0);
    ticks(3);
    chk("R1 stopped", int'(cntValue), 0);

    // R4 R5: active cycles over one full PWM cycle
    for (int v = 0; v < NVEC; v++) begin
      int act;
      wr(2'd0, VEC_PRD[v]);
      wr(2'd1, VEC_CMP[v]);
      wr(2'd3, 1 | (VEC_LOW[v] << 4));
      ticks(2);
      act = 0;
      for (int c = 0; c <= VEC_PRD[v]; c++) begin
        if (pwmOut == 1'b1) act++;
        tick();
      end
      chk(VEC_LOW[v] != 0 ? "R5 active-low duty" : "R4 duty", act, VEC_EXP[v]);
    end

    // bring counter to 0, stopped
    wr(2'd3, 2);
    wr(2'd2, 0);
    pulseSync();
    chk("R6 load zero", int'(cntValue), 0);

    wr(2'd0, 9);
    ticks(3);
    chk("R3 hold", int'(cntValue), 0);
    wr(2'd3, 1 | (1 << 2));
    chk("R11 write delay", int'(cntValue), 0);
    tick();
    chk("R2 step", int'(cntValue), 1);
    ticks(8);
    chk("R2 reach period", int'(cntValue), 9);
    chk("R8 no early pulse", int'(syncOut), 0);
    tick();
    chk("R2 wrap", int'(cntValue), 0);
    chk("R8 pulse", int'(syncOut), 1);
    tick();
    chk("R8 one clock", int'(syncOut), 0);
    chk("R2 after wrap", int'(cntValue), 1);

    wr(2'd2, 6);
    pulseSync();
    chk("R7 ignored", int'(cntValue), 3);
    wr(2'd3, 1 | 2 | 8);
    chk("R11 ctrl", int'(cntValue), 4);
    pulseSync();
    chk("R6 load", int'(cntValue), 6);
    chk("R9 pass", int'(syncOut), 1);
    tick();
    chk("R9 pass end", int'(syncOut), 0);
    ticks(2);
    chk("R2 at period", int'(cntValue), 9);
    pulseSync();
    chk("R6 priority over wrap", int'(cntValue), 6);

    wr(2'd3, 2 | 8);
    tick();
    chk("R3 stopped", int'(cntValue), 7);
    pulseSync();
    chk("R6 load while stopped", int'(cntValue), 6);

    // R10 both off encodings
    begin
      int seen = 0;
      wr(2'd3, 1 | 2 | 12);
      for (int i = 0; i < 12; i++) begin
        syncIn = (i == 4);
        tick();
        if (syncOut) seen++;
      end
      syncIn = 1'b0;
      chk("R10 sel 11", seen, 0);
      seen = 0;
      wr(2'd3, 1 | 2);
      for (int i = 0; i < 12; i++) begin
        syncIn = (i == 4);
        tick();
        if (syncOut) seen++;
      end
      syncIn = 1'b0;
      chk("R10 sel 00", seen, 0);
    end

    // R2 counter above period returns to zero
    wr(2'd3, 2);
    wr(2'd2, 15);
    pulseSync();
    tick();
    chk("R2 stranded hold", int'(cntValue), 15);
    wr(2'd3, 1);
    chk("R2 stranded pre", int'(cntValue), 15);
    tick();
    chk("R2 above period", int'(cntValue), 0);

    finishRun();
  end
endmodule